// File: doc/BRIEF.md
# Slot-Table Time-Division Memory Arbiter

This block shares one memory port among up to fifteen requesting clients. Bandwidth is set by a 64-entry slot table. Each entry names the client that owns that slot. A slot pointer walks the table, and at each grant decision the client named in the current entry is granted if it is requesting. When the named client is idle, or when the entry names no valid client, the slot goes to the lowest-numbered client that is requesting. A client that owns no slots can therefore still reach memory, but only through slots that their owners leave unused.

Once granted, a client keeps the port for a bounded number of cycles. Each client has its own programmable burst limit. The grant ends when the limit is used up or when the client drops its request, whichever comes first. The slot table and the burst limits share one write port: a kind bit selects the target, an address picks the slot or the client, and a data word carries the value. Software that computes the table contents lies outside the block.

Top module: `tdm_slot_arbiter`

## Requirements
- R1: After reset, `gnt` is all zero, `slot_ptr` is 0, every slot entry holds the unowned code 15, and every burst limit is 3.
- R2: A write with `wr_kind`=0 stores `wr_data` as the owner of slot `wr_addr`. A write with `wr_kind`=1 stores `wr_data` as the burst limit of client `wr_addr`. A new owner value is used from the next grant decision onward.
- R3: When the owner named by the entry at `slot_ptr` is requesting at a grant decision, that owner wins, even if lower-numbered clients are also requesting.
- R4: When the owner of the current slot is not requesting, the requester with the lowest index wins.
- R5: An entry value of 15 (outside 0..14) is unowned, and its slot always goes through the lowest-index fallback. A client that owns no slot is still granted through that fallback.
- R6: `gnt` is registered and at most one bit of it is set. It stays zero while no client requests. From an idle cycle with requests present, the grant appears on the next clock edge.
- R7: A client that keeps requesting holds `gnt` for exactly its burst limit plus one cycles. `gnt` is then zero for one cycle before the next decision.
- R8: If the granted client drops its request, `gnt` goes to zero on the next clock edge.
- R9: `slot_ptr` advances by one when a grant ends, or on each idle cycle with no request. It holds while a grant is in progress and wraps from 63 to 0.
- R10: A slot-table write made during a grant changes neither the granted client nor the length of its burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 15 | Request, one bit per client |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 1 | 0 = slot-table entry, 1 = burst limit |
| wr_addr | input | 6 | Slot number, or client index for a burst limit |
| wr_data | input | 4 | Client index, or burst limit |
| gnt | output | 15 | One-hot registered grant |
| slot_ptr | output | 6 | Current slot-table position |

## Verification
The hardest situation to reach from the ports is a table write that lands in the middle of a long burst. The pointer moves on its own whenever the port is idle, so the bench cannot aim at a fixed slot. It first fills the whole table with one owner. It then lengthens that owner's burst to sixteen cycles and grants it. While that grant is running, it overwrites the entry at the pointer value shown on `slot_ptr`. The bench then checks that the grant keeps its owner and its full length. Owner priority is tested only after the whole table has been filled, so the result does not depend on where the pointer happens to be.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;
   typedef enum logic {
      CFG_SLOT  = 1'b0,
      CFG_BURST = 1'b1
   } cfg_kind_e;
endpackage

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
   parameter int N_SLOTS = 64,
   parameter int IDX_W   = 4,
   parameter int SW      = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [SW-1:0]    waddr,
   input  logic [IDX_W-1:0] wdata,
   input  logic [SW-1:0]    raddr,
   output logic [IDX_W-1:0] rdata
);
   logic [IDX_W-1:0] entry_q [N_SLOTS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < N_SLOTS; s++) entry_q[s] <= '1;
      end else if (we) begin
         entry_q[waddr] <= wdata;
      end
   end

   assign rdata = entry_q[raddr];
endmodule

// File: rtl/tdm_burst_regs.sv
module tdm_burst_regs #(
   parameter int N_CLIENTS = 15,
   parameter int IDX_W     = 4,
   parameter int SW        = 6,
   parameter int BURST_W   = 4,
   parameter int DEF_BURST = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [SW-1:0]      waddr,
   input  logic [BURST_W-1:0] wdata,
   input  logic [IDX_W-1:0]   sel,
   output logic [BURST_W-1:0] lim
);
   logic [BURST_W-1:0] lim_q [N_CLIENTS];

   for (genvar c = 0; c < N_CLIENTS; c++) begin : g_client
      always_ff @(posedge clk) begin
         if (!rst_n)                           lim_q[c] <= BURST_W'(DEF_BURST);
         else if (we && waddr == SW'(c))       lim_q[c] <= wdata;
      end
   end

   always_comb begin
      lim = '0;
      for (int c = 0; c < N_CLIENTS; c++)
         if (sel == IDX_W'(c)) lim = lim_q[c];
   end
endmodule

// File: rtl/tdm_grant_pick.sv
module tdm_grant_pick #(
   parameter int N_CLIENTS = 15,
   parameter int IDX_W     = 4
) (
   input  logic [N_CLIENTS-1:0] req,
   input  logic [IDX_W-1:0]     owner,
   output logic                 any,
   output logic [IDX_W-1:0]     win
);
   logic own_hit;

   always_comb begin
      own_hit = 1'b0;
      for (int c = 0; c < N_CLIENTS; c++)
         if (owner == IDX_W'(c) && req[c]) own_hit = 1'b1;
   end

   always_comb begin
      any = |req;
      win = '0;
      if (own_hit) begin
         win = owner;
      end else begin
         for (int c = N_CLIENTS - 1; c >= 0; c--)
            if (req[c]) win = IDX_W'(c);
      end
   end
endmodule

// File: rtl/tdm_slot_arbiter.sv
module tdm_slot_arbiter
   import tdm_arb_pkg::*;
#(
   parameter int N_CLIENTS = 15,
   parameter int N_SLOTS   = 64,
   parameter int BURST_W   = 4,
   parameter int DEF_BURST = 3,
   localparam int IDX_W    = $clog2(N_CLIENTS + 1),
   localparam int SW       = $clog2(N_SLOTS),
   localparam int DW       = (IDX_W > BURST_W) ? IDX_W : BURST_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_CLIENTS-1:0] req,
   input  logic                 wr_en,
   input  logic                 wr_kind,
   input  logic [SW-1:0]        wr_addr,
   input  logic [DW-1:0]        wr_data,
   output logic [N_CLIENTS-1:0] gnt,
   output logic [SW-1:0]        slot_ptr
);
   if (N_CLIENTS < 2) begin : g_bad_clients
      $error("N_CLIENTS must be at least 2");
   end
   if (N_SLOTS < 2) begin : g_bad_slots
      $error("N_SLOTS must be at least 2");
   end
   if (SW < IDX_W) begin : g_bad_addr
      $error("slot address too narrow to select a client");
   end
   if (DEF_BURST >= (1 << BURST_W)) begin : g_bad_def
      $error("DEF_BURST does not fit in BURST_W");
   end

   logic                 busy_q;
   logic [IDX_W-1:0]     cur_q;
   logic [BURST_W-1:0]   beat_q;
   logic [N_CLIENTS-1:0] gnt_q;
   logic [SW-1:0]        ptr_q;
   logic [SW-1:0]        ptr_nxt;
   logic [IDX_W-1:0]     owner;
   logic [IDX_W-1:0]     win;
   logic                 any_req;
   logic [BURST_W-1:0]   lim;
   logic                 own_req;
   logic                 slot_we;
   logic                 burst_we;

   assign slot_we  = wr_en && (cfg_kind_e'(wr_kind) == CFG_SLOT);
   assign burst_we = wr_en && (cfg_kind_e'(wr_kind) == CFG_BURST);
   assign own_req  = |(req & gnt_q);

   tdm_slot_table #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W), .SW(SW)) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (slot_we),
      .waddr (wr_addr),
      .wdata (wr_data[IDX_W-1:0]),
      .raddr (ptr_q),
      .rdata (owner)
   );

   tdm_burst_regs #(.N_CLIENTS(N_CLIENTS), .IDX_W(IDX_W), .SW(SW),
                    .BURST_W(BURST_W), .DEF_BURST(DEF_BURST)) u_burst (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (burst_we),
      .waddr (wr_addr),
      .wdata (wr_data[BURST_W-1:0]),
      .sel   (cur_q),
      .lim   (lim)
   );

   tdm_grant_pick #(.N_CLIENTS(N_CLIENTS), .IDX_W(IDX_W)) u_pick (
      .req   (req),
      .owner (owner),
      .any   (any_req),
      .win   (win)
   );

   if ((1 << SW) == N_SLOTS) begin : g_wrap_pow2
      assign ptr_nxt = ptr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign ptr_nxt = (ptr_q == SW'(N_SLOTS - 1)) ? '0 : ptr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cur_q  <= '0;
         beat_q <= '0;
         gnt_q  <= '0;
         ptr_q  <= '0;
      end else if (busy_q) begin
         if (!own_req || beat_q == lim) begin
            busy_q <= 1'b0;
            gnt_q  <= '0;
            ptr_q  <= ptr_nxt;
         end else begin
            beat_q <= beat_q + 1'b1;
         end
      end else if (any_req) begin
         busy_q <= 1'b1;
         cur_q  <= win;
         beat_q <= '0;
         for (int c = 0; c < N_CLIENTS; c++) gnt_q[c] <= (win == IDX_W'(c));
      end else begin
         ptr_q <= ptr_nxt;
      end
   end

   assign gnt      = gnt_q;
   assign slot_ptr = ptr_q;
endmodule

// File: rtl/tdm_arb_chk.sv
module tdm_arb_chk #(
   parameter int N_CLIENTS = 15,
   parameter int SW        = 6,
   parameter int BURST_W   = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_CLIENTS-1:0] req,
   input logic [N_CLIENTS-1:0] gnt,
   input logic [SW-1:0]        slot_ptr
);
   logic [BURST_W+1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          run_q <= '0;
      else if (gnt == '0)  run_q <= '0;
      else                 run_q <= run_q + 1'b1;
   end

   p_gnt_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   p_idle_no_gnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && req == '0) |=> gnt == '0);

   p_start_to_requester_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && req != '0) |=> (gnt & $past(req)) != '0);

   p_drop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0 && (gnt & req) == '0) |=> gnt == '0);

   p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && req == '0) |=> slot_ptr == SW'($past(slot_ptr) + 1'b1));

   p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && req != '0) |=> $stable(slot_ptr));

   p_burst_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= (BURST_W+2)'(1 << BURST_W));
endmodule

bind tdm_slot_arbiter tdm_arb_chk #(
   .N_CLIENTS(N_CLIENTS), .SW(SW), .BURST_W(BURST_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req      (req),
   .gnt      (gnt),
   .slot_ptr (slot_ptr)
);

// File: tb/tdm_slot_arbiter_tb.sv
`timescale 1ns/1ps
module tdm_slot_arbiter_tb;
   localparam int NC = 15;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NC-1:0] req;
   logic          wr_en;
   logic          wr_kind;
   logic [5:0]    wr_addr;
   logic [3:0]    wr_data;
   logic [NC-1:0] gnt;
   logic [5:0]    slot_ptr;

   int n_run  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   tdm_slot_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .wr_kind(wr_kind),
      .wr_addr(wr_addr), .wr_data(wr_data), .gnt(gnt), .slot_ptr(slot_ptr)
   );

   // fallback vectors with an all-unowned table: {req, expected grant}
   localparam logic [29:0] VEC [8] = '{
      {15'h0001, 15'h0001}, {15'h0006, 15'h0002}, {15'h7000, 15'h1000},
      {15'h4000, 15'h4000}, {15'h7FFF, 15'h0001}, {15'h0A08, 15'h0008},
      {15'h0100, 15'h0100}, {15'h6000, 15'h2000}
   };

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cfg(logic kind, int addr, int data);
      wr_en = 1'b1; wr_kind = kind; wr_addr = 6'(addr); wr_data = 4'(data);
      tick();
      wr_en = 1'b0;
   endtask

   task automatic fill_table(int owner);
      for (int s = 0; s < 64; s++) cfg(1'b0, s, owner);
   endtask

   // grant already seen this negedge; count remaining cycles of the same grant
   task automatic count_rest(logic [NC-1:0] g, inout int n);
      for (int k = 0; k < 40 && gnt == g; k++) begin
         n++;
         tick();
      end
      req = '0;
      tick();
   endtask

   initial begin
      #(4.0 * 200000);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int n;
      int p0;
      rst_n = 1'b0; req = '0; wr_en = 1'b0; wr_kind = 1'b0; wr_addr = '0; wr_data = '0;
      tick(); tick();
      rst_n = 1'b1;
      chk("R1 gnt after reset", int'(gnt), 0);
      chk("R1 ptr after reset", int'(slot_ptr), 0);

      // R4 R5: unowned reset table, fallback lowest index
      foreach (VEC[i]) begin
         req = VEC[i][29:15];
         tick();
         chk($sformatf("R4 R5 fallback vec%0d", i), int'(gnt), int'(VEC[i][14:0]));
         req = '0;
         tick();
         chk($sformatf("R8 drop vec%0d", i), int'(gnt), 0);
      end

      // R6 R9: idle, no grant, pointer steps
      p0 = int'(slot_ptr);
      tick();
      chk("R6 no request no grant", int'(gnt), 0);
      chk("R9 idle step", int'(slot_ptr), (p0 + 1) % 64);

      // R9 wrap
      for (int k = 0; k < 70 && slot_ptr != 6'd63; k++) tick();
      tick();
      chk("R9 wrap to 0", int'(slot_ptr), 0);

      // R7 default burst 4 cycles, pointer holds, one gap cycle
      req = 15'h0004;
      tick();
      p0 = int'(slot_ptr);
      n = 0;
      for (int k = 0; k < 40 && gnt == 15'h0004; k++) begin
         n++;
         if (k == 2) chk("R9 hold during grant", int'(slot_ptr), p0);
         tick();
      end
      chk("R7 default burst length", n, 4);
      chk("R9 advance at burst end", int'(slot_ptr), (p0 + 1) % 64);
      req = '0;
      tick();

      // R2 R7: burst limit 0 and 7
      cfg(1'b1, 2, 0);
      req = 15'h0004; tick(); n = 0; count_rest(15'h0004, n);
      chk("R7 burst limit 0", n, 1);
      cfg(1'b1, 2, 7);
      req = 15'h0004; tick(); n = 0; count_rest(15'h0004, n);
      chk("R7 burst limit 7", n, 8);

      // R8: drop mid-burst
      cfg(1'b1, 2, 15);
      req = 15'h0004; tick(); tick(); tick();
      chk("R8 still granted", int'(gnt), 32'h4);
      req = '0;
      tick();
      chk("R8 drop ends grant", int'(gnt), 0);
      tick();

      // R2 R3: owner beats lower index
      fill_table(5);
      req = 15'h0022; tick();
      chk("R3 owner wins over lower index", int'(gnt), 32'h20);
      req = '0; tick(); tick();
      req = 15'h0002; tick();
      chk("R5 slotless client via fallback", int'(gnt), 32'h2);
      req = '0; tick(); tick();

      // R10: table write during long burst
      cfg(1'b1, 5, 15);
      req = 15'h0022; tick();
      chk("R10 grant before write", int'(gnt), 32'h20);
      n = 1;
      cfg(1'b0, int'(slot_ptr), 1);
      count_rest(15'h0020, n);
      chk("R10 burst length kept", n, 16);

      // R3 boundary owner 14
      fill_table(14);
      req = 15'h4001; tick();
      chk("R3 owner 14 wins", int'(gnt), 32'h4000);
      req = '0; tick(); tick();

      // R5: unowned code 15 restores fallback
      fill_table(15);
      req = 15'h4001; tick();
      chk("R5 unowned code falls back", int'(gnt), 32'h1);
      req = '0; tick(); tick();

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule